// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a two-bank SDRAM. It owns the command pins from reset until the memory is usable. First it holds NOP with the clock running for a programmable settling pause. Then it issues a precharge to every bank, a series of auto-refresh commands, and a mode-register write that carries a configurable operating code. Once the mode-register delay has run out, it raises `ready`, and normal traffic may use the memory.

After that, the block keeps the array refreshed. An interval counter restarts at every auto-refresh it issues. When the counter runs out, the block raises a refresh request and holds it. When the arbiter grants the request, the block takes the command pins back. It closes all banks with a precharge-all, waits the precharge time, issues one auto-refresh, waits the row cycle time, and then hands the bus back.

All minimum gaps are given in picoseconds and converted to clock cycles at elaboration. Minimum gaps round up to whole cycles. The refresh interval rounds down, so refresh is never late.

Top module: `sdram_boot_refresh`

## Requirements
- R1: From reset release, the pins carry NOP for PAUSE cycles (cycles 0 to PAUSE-1). NOP is CS,RAS,CAS,WE = L,H,H,H. During these cycles `ready` and `ref_req` are low, the address is zero and `cke` is high.
- R2: In cycle PAUSE the block issues a precharge-all. This is CS,RAS,CAS,WE = L,L,H,L with address bit 8 high and every other address bit low.
- R3: The first auto-refresh (L,L,L,H) comes RP cycles after the precharge. INIT_REFS auto-refreshes follow, each exactly RC cycles after the previous one.
- R4: The mode-register write (L,L,L,L) comes RC cycles after the last initial auto-refresh. Address bits 8..0 carry MODE_CODE and bit 9 is low.
- R5: `ready` rises exactly MRD cycles after the mode-register write. Only NOPs appear in between.
- R6: The cycle counts are derived from the clock period. PAUSE, RC and RP are the rounded-up quotients of the durations by the period, with RC and RP at least 2. The refresh interval RI is the rounded-down quotient.
- R7: Once the block is ready, `ref_req` rises RI-RP-1 cycles after the most recent auto-refresh. It stays high until a cycle in which `ref_grant` is high.
- R8: A cycle with both `ref_req` and `ref_grant` high is followed by a precharge-all. In that following cycle `ready` and `ref_req` are low. An auto-refresh comes RP cycles after the precharge, and `ready` returns RC cycles after the auto-refresh.
- R9: `ref_grant` has no effect while `ref_req` is low. This holds both before `ready` and when the grant stays high after a refresh: no command appears and `ready` does not change.
- R10: If the grant arrives in the cycle the request rises, consecutive auto-refreshes are exactly RI cycles apart.
- R11: While `ready` is high, the pins carry NOP with a zero address. A command is never followed by another command sooner than its minimum gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change after its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Arbiter grant for a pending refresh |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | AW | Address pins; bit 8 selects all banks on precharge |
| ready | output | 1 | Memory initialised and bus free for normal traffic |
| ref_req | output | 1 | Refresh due, held until granted |

## Verification
Two events can land in the same cycle: the interval counter raising the refresh request, and the arbiter answering it. The bench sweeps the grant latency from zero, where the grant is driven in the very cycle `ref_req` first appears, up to seven cycles. For every latency it predicts the cycle of the precharge-all, the cycle of the auto-refresh and the cycle in which `ready` returns. The zero-latency round must place auto-refreshes exactly one interval apart. Another round keeps the grant high after the refresh completes, to show that a grant without a pending request starts nothing.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_INIT_PRE,
    ST_INIT_TRP,
    ST_INIT_REF,
    ST_INIT_TRC,
    ST_MODE,
    ST_MODE_WAIT,
    ST_READY,
    ST_RF_PRE,
    ST_RF_TRP,
    ST_RF_REF,
    ST_RF_TRC
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_NOP,
    OP_PRE_ALL,
    OP_AREF,
    OP_MODE
  } sdram_op_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  // Minimum gap: duration rounded up to whole cycles, never below floor_min.
  function automatic int unsigned span_cycles(input int unsigned dur_ps,
                                              input int unsigned clk_ps,
                                              input int unsigned floor_min);
    int unsigned q;
    q = dur_ps / clk_ps;
    if (q * clk_ps < dur_ps) q = q + 1;
    if (q < floor_min) q = floor_min;
    return q;
  endfunction

  // Maximum spacing: duration rounded down, so the deadline is never missed.
  function automatic int unsigned fit_cycles(input int unsigned dur_ps,
                                             input int unsigned clk_ps);
    return dur_ps / clk_ps;
  endfunction

  // Counter reload so that a grant in the request's first cycle lands the
  // auto-refresh exactly one interval after the previous one.
  function automatic int unsigned req_lead(input int unsigned interval,
                                           input int unsigned rp);
    return interval - rp - 2;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    int unsigned b;
    b = $clog2(v + 1);
    return (b < 1) ? 1 : b;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic pin_cmd_t encode_op(input sdram_op_t op);
    pin_cmd_t p;
    case (op)
      OP_PRE_ALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      OP_AREF:    p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      OP_MODE:    p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:    p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/seq_timer.sv
// Shared gap counter: loaded when a command issues, flags its last wait cycle.
module seq_timer #(
  parameter int unsigned W       = 16,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= W'(RST_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/refresh_interval.sv
// Interval counter: restarts on every auto-refresh, pulses when a refresh falls due.
module refresh_interval #(
  parameter int unsigned W   = 8,
  parameter int unsigned GAP = 46
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic due
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (reload)       cnt_q <= W'(GAP);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign due = (cnt_q == W'(1)) && !reload;
endmodule

// File: rtl/cmd_drive.sv
// Turns the abstract operation into pin levels and an address word.
module cmd_drive
  import sdram_seq_pkg::*;
#(
  parameter int unsigned   AW        = 10,
  parameter int unsigned   AP_BIT    = 8,
  parameter logic [AP_BIT:0] MODE_CODE = '0
) (
  input  sdram_op_t       op,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [AW-1:0]   addr
);
  pin_cmd_t pins;

  always_comb begin
    pins = encode_op(op);
    addr = '0;
    case (op)
      OP_PRE_ALL: addr[AP_BIT] = 1'b1;
      OP_MODE:    addr[AP_BIT:0] = MODE_CODE;
      default:    addr = '0;
    endcase
  end

  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;
endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
  import sdram_seq_pkg::*;
#(
  parameter int unsigned     CLK_PS          = 8000,
  parameter int unsigned     PAUSE_PS        = 200_000_000,
  parameter int unsigned     TRC_PS          = 72_000,
  parameter int unsigned     TRP_PS          = 24_000,
  parameter int unsigned     MRD_CYC         = 2,
  parameter int unsigned     INIT_REFS       = 8,
  parameter int unsigned     REF_INTERVAL_PS = 15_625_000,
  parameter int unsigned     AW              = 10,
  parameter int unsigned     AP_BIT          = 8,
  parameter logic [AP_BIT:0] MODE_CODE       = 9'h022
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_grant,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic          ready,
  output logic          ref_req
);
  localparam int unsigned PAUSE_CYC = span_cycles(PAUSE_PS, CLK_PS, 1);
  localparam int unsigned RC_CYC    = span_cycles(TRC_PS, CLK_PS, 2);
  localparam int unsigned RP_CYC    = span_cycles(TRP_PS, CLK_PS, 2);
  localparam int unsigned MRD       = (MRD_CYC < 2) ? 2 : MRD_CYC;
  localparam int unsigned RI_CYC    = fit_cycles(REF_INTERVAL_PS, CLK_PS);
  localparam int unsigned REQ_GAP   = req_lead(RI_CYC, RP_CYC);
  localparam int unsigned TW        = bits_for(max3(PAUSE_CYC, RC_CYC, max3(RP_CYC, MRD, 1)));
  localparam int unsigned IW        = bits_for(REQ_GAP);
  localparam int unsigned NW        = bits_for(INIT_REFS);
  localparam int unsigned GMAX      = RC_CYC + RP_CYC + MRD + 4;
  localparam int unsigned GW        = bits_for(GMAX);

  seq_state_t    state_q, state_d;
  sdram_op_t     op;
  logic          tm_load, tm_last;
  logic [TW-1:0] tm_val;
  logic [NW-1:0] nref_q;
  logic          refs_done;
  logic          aref_issue;
  logic          ri_due;
  logic          pend_q;
  logic          grant_take;

  seq_timer #(.W(TW), .RST_VAL(PAUSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .last(tm_last)
  );

  refresh_interval #(.W(IW), .GAP(REQ_GAP)) u_interval (
    .clk(clk), .rst_n(rst_n), .reload(aref_issue), .due(ri_due)
  );

  cmd_drive #(.AW(AW), .AP_BIT(AP_BIT), .MODE_CODE(MODE_CODE)) u_drive (
    .op(op), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
  );

  assign refs_done  = (nref_q == NW'(INIT_REFS));
  assign grant_take = (state_q == ST_READY) && pend_q && ref_grant;

  always_comb begin
    state_d    = state_q;
    op         = OP_NOP;
    tm_load    = 1'b0;
    tm_val     = '0;
    aref_issue = 1'b0;
    case (state_q)
      ST_PAUSE:     if (tm_last) state_d = ST_INIT_PRE;
      ST_INIT_PRE: begin
        op      = OP_PRE_ALL;
        tm_load = 1'b1;
        tm_val  = TW'(RP_CYC - 1);
        state_d = ST_INIT_TRP;
      end
      ST_INIT_TRP:  if (tm_last) state_d = ST_INIT_REF;
      ST_INIT_REF: begin
        op         = OP_AREF;
        aref_issue = 1'b1;
        tm_load    = 1'b1;
        tm_val     = TW'(RC_CYC - 1);
        state_d    = ST_INIT_TRC;
      end
      ST_INIT_TRC:  if (tm_last) state_d = refs_done ? ST_MODE : ST_INIT_REF;
      ST_MODE: begin
        op      = OP_MODE;
        tm_load = 1'b1;
        tm_val  = TW'(MRD - 1);
        state_d = ST_MODE_WAIT;
      end
      ST_MODE_WAIT: if (tm_last) state_d = ST_READY;
      ST_READY:     if (grant_take) state_d = ST_RF_PRE;
      ST_RF_PRE: begin
        op      = OP_PRE_ALL;
        tm_load = 1'b1;
        tm_val  = TW'(RP_CYC - 1);
        state_d = ST_RF_TRP;
      end
      ST_RF_TRP:    if (tm_last) state_d = ST_RF_REF;
      ST_RF_REF: begin
        op         = OP_AREF;
        aref_issue = 1'b1;
        tm_load    = 1'b1;
        tm_val     = TW'(RC_CYC - 1);
        state_d    = ST_RF_TRC;
      end
      ST_RF_TRC:    if (tm_last) state_d = ST_READY;
      default:      state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAUSE;
      nref_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_INIT_REF) nref_q <= nref_q + 1'b1;
      if (grant_take)             pend_q <= 1'b0;
      else if (ri_due)            pend_q <= 1'b1;
    end
  end

  assign ready   = (state_q == ST_READY);
  assign ref_req = pend_q && ready;
  assign cke     = 1'b1;

  // Command history for the gap checks below.
  sdram_op_t     last_op_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op_q <= OP_NOP;
      gap_q     <= '0;
    end else if (op != OP_NOP) begin
      last_op_q <= op;
      gap_q     <= GW'(1);
    end else if (gap_q != GW'(GMAX)) begin
      gap_q     <= gap_q + 1'b1;
    end
  end

  p_ref_after_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AREF && last_op_q == OP_PRE_ALL) |-> gap_q >= GW'(RP_CYC));

  p_ref_after_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AREF && last_op_q == OP_AREF) |-> gap_q >= GW'(RC_CYC));

  p_mode_after_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MODE) |-> (last_op_q == OP_AREF && gap_q >= GW'(RC_CYC)));

  p_ready_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ((last_op_q == OP_MODE) ? (gap_q >= GW'(MRD)) : (gap_q >= GW'(RC_CYC))));

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant) |=> ref_req);

  p_grant_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_grant) |=> (op == OP_PRE_ALL && addr[AP_BIT] && !ready && !ref_req));

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ref_req) |=> ready);

  p_quiet_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == '0));

endmodule

// File: tb/tb_sdram_boot_refresh.sv
`timescale 1ns/1ps
module tb_sdram_boot_refresh;
  localparam int CLK_PS   = 20000;
  localparam int PAUSE_PS = 400000;
  localparam int TRC_PS   = 72000;
  localparam int TRP_PS   = 24000;
  localparam int MRD      = 2;
  localparam int NREF     = 8;
  localparam int RINT_PS  = 1_000_000;
  localparam logic [8:0] MODE = 9'h032;

  // Expected cycle counts, worked out independently.
  localparam int E_PAUSE = (PAUSE_PS + CLK_PS - 1) / CLK_PS;
  localparam int E_RC    = (TRC_PS + CLK_PS - 1) / CLK_PS;
  localparam int E_RP    = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int E_RI    = RINT_PS / CLK_PS;
  localparam int E_LEAD  = E_RI - E_RP - 1;

  localparam logic [3:0] K_NOP = 4'b0111;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_REF = 4'b0001;
  localparam logic [3:0] K_MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, ref_grant = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, ref_req;
  logic [9:0] addr;

  int vecs = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdram_boot_refresh #(
    .CLK_PS(CLK_PS), .PAUSE_PS(PAUSE_PS), .TRC_PS(TRC_PS), .TRP_PS(TRP_PS),
    .MRD_CYC(MRD), .INIT_REFS(NREF), .REF_INTERVAL_PS(RINT_PS),
    .AW(10), .AP_BIT(8), .MODE_CODE(MODE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ready(ready), .ref_req(ref_req)
  );

  task automatic vec(input logic [3:0] ecmd, input logic [9:0] eaddr,
                     input logic erdy, input logic ereq, input string tag);
    logic [3:0] got;
    got = {cs_n, ras_n, cas_n, we_n};
    vecs++;
    if (got !== ecmd || addr !== eaddr || ready !== erdy || ref_req !== ereq || cke !== 1'b1) begin
      fails++;
      $display("FAIL %s cycle %0d: cmd=%b addr=%h ready=%b req=%b cke=%b expected cmd=%b addr=%h ready=%b req=%b cke=1",
               tag, cyc, got, addr, ready, ref_req, cke, ecmd, eaddr, erdy, ereq);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual no finish, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int pre_c, ref0, mrs_c, rdy_c, last_ref;
    logic [3:0] ec; logic [9:0] ea; string tg;
    ref_grant = 1'b1;            // R9: grant held during init must be ignored
    repeat (3) @(negedge clk);
    vec(K_NOP, 10'h000, 1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    cyc = 0;

    pre_c = E_PAUSE;
    ref0  = pre_c + E_RP;
    mrs_c = ref0 + NREF * E_RC;
    rdy_c = mrs_c + MRD;
    last_ref = ref0 + (NREF - 1) * E_RC;

    while (cyc <= rdy_c + 3) begin
      ec = K_NOP; ea = 10'h000; tg = "R1 R6 R9 pause";
      if (cyc == pre_c) begin ec = K_PRE; ea = 10'h100; tg = "R2 R6"; end
      else if (cyc >= ref0 && cyc < mrs_c && (cyc - ref0) % E_RC == 0) begin ec = K_REF; tg = "R3"; end
      else if (cyc == mrs_c) begin ec = K_MRS; ea = {1'b0, MODE}; tg = "R4"; end
      else if (cyc > mrs_c && cyc < rdy_c) tg = "R5";
      else if (cyc >= rdy_c) tg = "R5 R9 R11";
      else if (cyc > pre_c) tg = "R3 R11";
      vec(ec, ea, (cyc >= rdy_c), 1'b0, tg);
      ref_grant = (cyc <= rdy_c + 1);
      @(negedge clk);
      cyc++;
    end

    for (int r = 0; r < 8; r++) begin
      int rise, g, pc, rc, back;
      bit hold;
      rise = last_ref + E_LEAD;
      g    = rise + r;
      pc   = g + 1;
      rc   = pc + E_RP;
      back = rc + E_RC;
      hold = (r == 5);
      while (cyc <= back + 2) begin
        ec = K_NOP; ea = 10'h000; tg = "R11";
        if (cyc >= rise && cyc <= g) tg = "R7";
        if (cyc == pc) begin ec = K_PRE; ea = 10'h100; tg = "R8"; end
        else if (cyc == rc) begin ec = K_REF; tg = (r == 0) ? "R10" : "R8"; end
        else if (cyc > pc && cyc < back) tg = "R8";
        else if (hold && cyc >= back) tg = "R9";
        vec(ec, ea, !(cyc >= pc && cyc < back), (cyc >= rise && cyc <= g), tg);
        ref_grant = (cyc == g) || (hold && cyc >= g && cyc <= back + 2);
        @(negedge clk);
        cyc++;
      end
      ref_grant = 1'b0;
      last_ref = rc;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule